// File: doc/BRIEF.md
# Multi-Domain Reset Release Sequencer

This block turns one external active-low asynchronous reset into one active-low reset per clock domain. While the external reset is low, every domain reset is held active and the completion flag is held low, with no clock needed. Once the external reset goes high, the domains leave reset one after another in index order, 0 first. Each release is retimed onto the domain's own clock by a two-flop chain.

A central controller runs on its own clock. It reads back each domain's reset state through a two-flop synchronizer and uses the synchronized status of domain k-1 as the release request for domain k. Domain 0 needs only the external reset to be high. The system start-up order is therefore fixed by design, not set by whichever local synchronizer finishes first. One controller clock after the last domain's synchronized status shows it out of reset, the controller raises a completion flag. If the external reset drops at any point, all outputs return to the reset state at once and the sequence starts again from domain 0.

Top module: `rst_seq_top`

## Requirements
- R1: While rst_ni is low, every bit of dom_rst_no is 0 and seq_done_o is 0. This holds at once on assertion, from any point in the sequence, and also when every clock is stopped.
- R2: After rst_ni goes high, dom_rst_no[0] goes to 1 on the second rising edge of dom_clk_i[0], counting only edges that come after the deassertion. With that clock stopped, it stays 0.
- R3: For k > 0, dom_rst_no[k] goes to 1 on the second rising edge of dom_clk_i[k], counting only edges after the second rising edge of clk_i that follows the release of dom_rst_no[k-1].
- R4: A domain output goes from 0 to 1 only at the same instant as a rising edge of that domain's own clock.
- R5: dom_rst_no[k] is never 1 while dom_rst_no[k-1] is 0. If dom_clk_i[k] is stopped, domain k and every higher domain stay in reset, and seq_done_o stays 0.
- R6: seq_done_o rises on the third rising edge of clk_i after dom_rst_no[N_DOM-1] is released. It is 1 only while all domain outputs are 1.
- R7: If rst_ni is asserted again in mid-sequence or after completion, the next release repeats the complete sequence from domain 0 with the timing of R2, R3 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | External asynchronous reset, active low |
| dom_clk_i | input | N_DOM | One clock per domain |
| dom_rst_no | output | N_DOM | Per-domain reset, active low, released synchronously to its clock |
| seq_done_o | output | 1 | High once every domain is out of reset |

## Verification
Two functions can fall into the same stretch of time: re-assertion of the external reset, and a release step in progress (a domain output rising, or the completion flag rising). The stimulus table releases the reset and then pulls it low again after short waits, while a domain chain is still mid-flight and also after completion. It checks that every output is low one nanosecond later. The full sequence that follows is then judged by counting clock edges from each domain's release trigger: exactly two own-clock edges per domain and exactly three controller edges for the completion flag. Stopped clocks show that assertion needs no clock and that a stalled domain holds back every later domain.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  // Depth of every release and status synchronizer
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rst_seq_domain.sv
module rst_seq_domain #(
  parameter int unsigned STAGES = 2
) (
  input  logic dom_clk_i,
  input  logic rst_ni,
  input  logic rel_req_i,
  output logic dom_rst_no
);
  // Assertion is asynchronous through rst_ni; release is retimed to dom_clk_i
  rst_seq_sync #(.STAGES(STAGES)) i_rel_sync (
    .clk_i  (dom_clk_i),
    .rst_ni (rst_ni),
    .d_i    (rel_req_i),
    .q_o    (dom_rst_no)
  );
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int unsigned N_DOM  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DOM-1:0] dom_rst_ni,
  output logic [N_DOM-1:0] rel_req_o,
  output logic             seq_done_o
);
  logic [N_DOM-1:0] stat_s;
  logic             done_q;

  for (genvar k = 0; k < N_DOM; k++) begin : g_stat
    rst_seq_sync #(.STAGES(STAGES)) i_stat_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (dom_rst_ni[k]),
      .q_o    (stat_s[k])
    );
    if (k == 0) begin : g_first
      assign rel_req_o[k] = 1'b1;
    end else begin : g_chain
      assign rel_req_o[k] = stat_s[k-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= stat_s[N_DOM-1];
  end

  assign seq_done_o = done_q;
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int unsigned N_DOM  = 3,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DOM-1:0] dom_clk_i,
  output logic [N_DOM-1:0] dom_rst_no,
  output logic             seq_done_o
);
  logic [N_DOM-1:0] rel_req;

  rst_seq_ctrl #(.N_DOM(N_DOM), .STAGES(STAGES)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dom_rst_ni (dom_rst_no),
    .rel_req_o  (rel_req),
    .seq_done_o (seq_done_o)
  );

  for (genvar k = 0; k < N_DOM; k++) begin : g_dom
    rst_seq_domain #(.STAGES(STAGES)) i_dom (
      .dom_clk_i  (dom_clk_i[k]),
      .rst_ni     (rst_ni),
      .rel_req_i  (rel_req[k]),
      .dom_rst_no (dom_rst_no[k])
    );
  end
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int unsigned N_DOM = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_DOM-1:0] dom_clk_i,
  input logic [N_DOM-1:0] dom_rst_no,
  input logic             seq_done_o
);
  assert_reset_all_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (dom_rst_no == '0 && !seq_done_o));

  assert_done_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |-> &dom_rst_no);

  assert_done_lag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seq_done_o) |-> ($past(dom_rst_no[N_DOM-1], 3) && !$past(dom_rst_no[N_DOM-1], 4)));

  assert_first_rel_R2: assert property (@(posedge dom_clk_i[0]) disable iff (!rst_ni)
    $rose(dom_rst_no[0]) |-> $past(rst_ni, 2));

  for (genvar k = 1; k < N_DOM; k++) begin : g_chain
    assert_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dom_rst_no[k] |-> dom_rst_no[k-1]);

    assert_chain_rel_R3: assert property (@(posedge dom_clk_i[k]) disable iff (!rst_ni)
      $rose(dom_rst_no[k]) |-> $past(dom_rst_no[k-1], 2));
  end
endmodule

bind rst_seq_top rst_seq_chk #(.N_DOM(N_DOM)) i_rst_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dom_clk_i  (dom_clk_i),
  .dom_rst_no (dom_rst_no),
  .seq_done_o (seq_done_o)
);

// File: tb/test_rst_seq_top.sv
`timescale 1ns/10ps
module test_rst_seq_top;
  localparam int N = 3;

  typedef struct packed {
    int       wait_ns;
    bit       chk_out;
    logic [2:0] exp_rst;
    bit       exp_done;
    bit       chk_mon;
  } vec_t;

  // release, wait, optionally judge outputs and edge counts; next entry re-asserts reset
  localparam vec_t VEC [6] = '{
    '{300, 1'b1, 3'b111, 1'b1, 1'b1},
    '{3,   1'b1, 3'b000, 1'b0, 1'b0},
    '{20,  1'b0, 3'b000, 1'b0, 1'b0},
    '{300, 1'b1, 3'b111, 1'b1, 1'b1},
    '{60,  1'b0, 3'b000, 1'b0, 1'b0},
    '{400, 1'b1, 3'b111, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] run = '1;
  logic [N-1:0] dclk;
  logic [N-1:0] drst;
  logic done;

  logic [N-1:0][7:0] mon_rises;
  logic [N-1:0][7:0] mon_cnt;
  logic [N-1:0]      mon_edge;
  logic [N-1:0]      mon_order;

  always #5 clk = ~clk;

  rst_seq_top #(.N_DOM(N)) i_rst_seq_top (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .dom_clk_i  (dclk),
    .dom_rst_no (drst),
    .seq_done_o (done)
  );

  for (genvar k = 0; k < N; k++) begin : g_mon
    localparam real HALF = (k == 0) ? 4.0 : (k == 1) ? 7.0 : 3.0;
    localparam real OFF  = (k == 0) ? 0.3 : (k == 1) ? 0.7 : 0.1;
    logic c = 1'b0;
    logic prev;
    int ctl_cnt = 0;
    int dom_cnt = 0;
    int rises = 0;
    int cnt_at = 0;
    logic edge_ok = 1'b0;
    logic order_ok = 1'b0;
    realtime t_edge = 0.0;

    initial begin
      #(OFF);
      forever begin
        #(HALF);
        if (run[k]) c = ~c;
      end
    end
    assign dclk[k] = c;

    // release trigger of this domain: external reset for 0, previous domain otherwise
    assign prev = (k == 0) ? rst_n : drst[(k == 0) ? 0 : k - 1];

    always @(posedge clk or negedge prev)
      if (!prev) ctl_cnt = 0;
      else       ctl_cnt++;

    always @(posedge c or negedge prev)
      if (!prev) dom_cnt = 0;
      else begin
        t_edge = $realtime;
        if (k == 0 || ctl_cnt >= 2) dom_cnt++;
      end

    always @(posedge drst[k]) begin
      realtime tr;
      tr = $realtime;
      #0.05;
      cnt_at   = dom_cnt;
      edge_ok  = (t_edge == tr);
      order_ok = prev;
      rises++;
    end

    assign mon_rises[k] = rises[7:0];
    assign mon_cnt[k]   = cnt_at[7:0];
    assign mon_edge[k]  = edge_ok;
    assign mon_order[k] = order_ok;
  end

  int d_cnt = 0;
  int d_at = 0;
  int d_rises = 0;
  logic d_all = 1'b0;

  always @(posedge clk or negedge drst[N-1])
    if (!drst[N-1]) d_cnt = 0;
    else            d_cnt++;

  always @(posedge done) begin
    #0.05;
    d_at  = d_cnt;
    d_all = &drst;
    d_rises++;
  end

  int n_tests = 0;
  int n_fail = 0;
  logic [N-1:0][7:0] base;
  int dbase;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // assert reset, check at once (R1), then release on a controller falling edge
  task automatic start_seq();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(drst == '0, "R1 domain resets active at once", int'(drst), 0);
    chk(done == 1'b0, "R1 R7 done cleared at once", int'(done), 0);
    #19;
    base  = mon_rises;
    dbase = d_rises;
    rst_n = 1'b1;
  endtask

  task automatic check_full();
    for (int k = 0; k < N; k++) begin
      chk(int'(mon_rises[k] - base[k]) == 1, "R7 one release per domain", int'(mon_rises[k] - base[k]), 1);
      if (k == 0)
        chk(mon_cnt[k] == 2, "R2 domain 0 own-clock edges", int'(mon_cnt[k]), 2);
      else
        chk(mon_cnt[k] == 2, "R3 chained own-clock edges", int'(mon_cnt[k]), 2);
      chk(mon_edge[k], "R4 release on own rising edge", int'(mon_edge[k]), 1);
      chk(mon_order[k], "R5 previous domain released first", int'(mon_order[k]), 1);
    end
    chk(d_rises - dbase == 1, "R6 one done rise", d_rises - dbase, 1);
    chk(d_at == 3, "R6 done lag in controller edges", d_at, 3);
    chk(d_all, "R6 all domains out at done", int'(d_all), 1);
  endtask

  task automatic run_all();
    for (int i = 0; i < 6; i++) begin
      start_seq();
      #(VEC[i].wait_ns);
      if (VEC[i].chk_out) begin
        chk(drst == VEC[i].exp_rst, "R2 R7 domain outputs", int'(drst), int'(VEC[i].exp_rst));
        chk(done == VEC[i].exp_done, "R6 R7 done output", int'(done), int'(VEC[i].exp_done));
      end
      if (VEC[i].chk_mon) check_full();
    end

    // all clocks stopped: assertion needs no clock, release needs one (R1, R2)
    @(negedge clk);
    run = '0;
    start_seq();
    #100;
    chk(drst == '0, "R2 no release without own clock", int'(drst), 0);
    chk(done == 1'b0, "R2 no done without domain clocks", int'(done), 0);
    run = '1;
    #300;
    chk(drst == 3'b111, "R2 release after clocks resume", int'(drst), 7);
    check_full();

    // domain 1 clock stopped: later domains held back (R5)
    @(negedge clk);
    run[1] = 1'b0;
    start_seq();
    #300;
    chk(drst == 3'b001, "R5 stalled domain blocks later ones", int'(drst), 1);
    chk(done == 1'b0, "R5 done held while stalled", int'(done), 0);
    run[1] = 1'b1;
    #300;
    chk(drst == 3'b111, "R5 chain completes after resume", int'(drst), 7);
    check_full();
  endtask

  initial begin
    fork
      run_all();
      begin
        #100000;
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule